// File: doc/BRIEF.md
# Next-Interrupt Number Encoder

This block turns the raw pending state of a three-bank interrupt controller into the number of the single source a handler should service next. It takes a 32-bit summary word from the top bank and the full 32-bit pending words of the two lower banks. It returns one encoded number and a valid flag, which saves the handler a bit-by-bit search in software on every entry. The summary word carries eight local sources of its own, two cascade bits that stand for "something in bank 1 or bank 2 is pending", and eleven shortcut bits. Each shortcut bit reports one specific, frequently used source in bank 1 or bank 2 directly.

All inputs are sampled on a rising clock edge, and the result appears on registered outputs after that edge. The block does not mask, acknowledge or hold any pending state. It only decodes the words it is given. There is one exception: a sticky flag records a cascade bit that pointed at an empty bank.

Top module: `nxt_irq_encoder`

## Requirements
- R1: The output number is {1'b0, bank[1:0], bit[4:0]}, which is bank*32 + bit. Bank 0 numbers stay below 8, and bank 3 never appears.
- R2: Summary bits 31:21 are ignored. A summary word with only those bits set gives the same result as a zero word.
- R3: When no summary bit in 20:0 is set, the number is 8'hFF and valid is low.
- R4: Priority runs as follows: summary bits 7:0 (bank 0 local sources), then shortcut bits 14:10, then shortcut bits 20:15, then cascade bit 8 (bank 1), then cascade bit 9 (bank 2).
- R5: Within any one group, the lowest-numbered set bit wins.
- R6: Shortcut bits 10, 11, 12, 13 and 14 give bank 1 sources 7, 9, 10, 18 and 19. Shortcut bits 15 through 20 give bank 2 sources 21, 22, 23, 24, 25 and 30.
- R7: When a cascade bit wins, the number is the lowest set bit of that bank's full pending word, encoded with that bank.
- R8: When a cascade bit wins and that bank's pending word is zero, the number is 8'hFF, valid is low and the error flag is set.
- R9: The error flag stays set until reset, whatever the inputs do afterwards.
- R10: The outputs change one clock edge after the inputs are sampled. While reset is held, and after it is released, the number is 8'hFF, valid is low and the error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sum_word | input | 32 | Summary word: local, cascade and shortcut bits |
| bank1_word | input | 32 | Full pending word of bank 1 |
| bank2_word | input | 32 | Full pending word of bank 2 |
| irq_num | output | 8 | Encoded number of the next source, 8'hFF if none |
| irq_valid | output | 1 | A source was found |
| cascade_err | output | 1 | Sticky: a cascade bit won but its bank was empty |

## Verification
The bench sets each summary bit alone, so a wrong entry in the shortcut table or a wrong bank in the encoding shows up as a wrong number for that one bit. Setting the ignored upper bits alone must give the idle code, so a design that failed to mask them would report a spurious source. Every pair of live summary bits is swept. This catches a design that ranks a cascade bit above a shortcut bit, or takes the highest set bit of a group instead of the lowest. A cascade bit aimed at an empty bank must give the idle code and a lasting error flag: a design that returned bit 0 of that bank, or cleared the flag on the next clean input, would fail.

// File: rtl/nxt_irq_pkg.sv
package nxt_irq_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_W     = 8;
  localparam int LOCAL_N   = 8;
  localparam int CASC1_BIT = 8;
  localparam int CASC2_BIT = 9;
  localparam int SC1_LO    = 10;
  localparam int SC1_N     = 5;
  localparam int SC2_LO    = SC1_LO + SC1_N;
  localparam int SC2_N     = 6;
  localparam int LIVE_TOP  = SC2_LO + SC2_N - 1;
  localparam logic [WORD_W-1:0] LIVE_MASK = (WORD_W'(1) << (LIVE_TOP + 1)) - WORD_W'(1);
  localparam logic [NUM_W-1:0]  NONE_CODE = '1;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_LOCAL, SRC_SC1, SRC_SC2, SRC_CASC1, SRC_CASC2
  } src_e;

  // Pack a bank and a bit index into the output number.
  function automatic logic [NUM_W-1:0] make_num(input logic [1:0] bank,
                                                input logic [4:0] bitn);
    return {1'b0, bank, bitn};
  endfunction

  // Shortcut slot (0..10, bank 1 slots first) to the true source bit.
  function automatic logic [4:0] sc_target(input logic [3:0] slot);
    logic [4:0] r;
    case (slot)
      4'd0:    r = 5'd7;
      4'd1:    r = 5'd9;
      4'd2:    r = 5'd10;
      4'd3:    r = 5'd18;
      4'd4:    r = 5'd19;
      4'd5:    r = 5'd21;
      4'd6:    r = 5'd22;
      4'd7:    r = 5'd23;
      4'd8:    r = 5'd24;
      4'd9:    r = 5'd25;
      default: r = 5'd30;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nxt_lsb_find.sv
module nxt_lsb_find #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/nxt_src_select.sv
module nxt_src_select
  import nxt_irq_pkg::*;
(
  input  logic [WORD_W-1:0] live,
  output src_e              win
);
  logic any_live, any_loc, any_sc1, any_sc2;

  assign any_live = |live;
  assign any_loc  = |live[LOCAL_N-1:0];
  assign any_sc1  = |live[SC1_LO +: SC1_N];
  assign any_sc2  = |live[SC2_LO +: SC2_N];

  always_comb begin
    if (!any_live)             win = SRC_NONE;
    else if (any_loc)          win = SRC_LOCAL;
    else if (any_sc1)          win = SRC_SC1;
    else if (any_sc2)          win = SRC_SC2;
    else if (live[CASC1_BIT])  win = SRC_CASC1;
    else                       win = SRC_CASC2;
  end
endmodule

// File: rtl/nxt_irq_encoder.sv
module nxt_irq_encoder
  import nxt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] sum_word,
  input  logic [WORD_W-1:0] bank1_word,
  input  logic [WORD_W-1:0] bank2_word,
  output logic [NUM_W-1:0]  irq_num,
  output logic              irq_valid,
  output logic              cascade_err
);
  localparam int LOC_IW = $clog2(LOCAL_N);
  localparam int SC1_IW = $clog2(SC1_N);
  localparam int SC2_IW = $clog2(SC2_N);
  localparam int BNK_IW = $clog2(WORD_W);

  logic [WORD_W-1:0] live;
  src_e              win_src;
  logic              loc_f, sc1_f, sc2_f, b1_f, b2_f;
  logic [LOC_IW-1:0] loc_idx;
  logic [SC1_IW-1:0] sc1_idx;
  logic [SC2_IW-1:0] sc2_idx;
  logic [BNK_IW-1:0] b1_idx, b2_idx;
  logic [NUM_W-1:0]  nxt_num;
  logic              casc_empty;

  assign live = sum_word & LIVE_MASK;

  nxt_src_select u_sel (.live(live), .win(win_src));

  nxt_lsb_find #(.W(LOCAL_N)) u_loc (.vec(live[LOCAL_N-1:0]),   .found(loc_f), .idx(loc_idx));
  nxt_lsb_find #(.W(SC1_N))   u_sc1 (.vec(live[SC1_LO +: SC1_N]), .found(sc1_f), .idx(sc1_idx));
  nxt_lsb_find #(.W(SC2_N))   u_sc2 (.vec(live[SC2_LO +: SC2_N]), .found(sc2_f), .idx(sc2_idx));
  nxt_lsb_find #(.W(WORD_W))  u_b1  (.vec(bank1_word), .found(b1_f), .idx(b1_idx));
  nxt_lsb_find #(.W(WORD_W))  u_b2  (.vec(bank2_word), .found(b2_f), .idx(b2_idx));

  always_comb begin
    nxt_num    = NONE_CODE;
    casc_empty = 1'b0;
    case (win_src)
      SRC_LOCAL: if (loc_f) nxt_num = make_num(2'd0, 5'(loc_idx));
      SRC_SC1:   if (sc1_f) nxt_num = make_num(2'd1, sc_target(4'(sc1_idx)));
      SRC_SC2:   if (sc2_f) nxt_num = make_num(2'd2, sc_target(4'(sc2_idx) + 4'(SC1_N)));
      SRC_CASC1: begin
        if (b1_f) nxt_num = make_num(2'd1, 5'(b1_idx));
        else      casc_empty = 1'b1;
      end
      SRC_CASC2: begin
        if (b2_f) nxt_num = make_num(2'd2, 5'(b2_idx));
        else      casc_empty = 1'b1;
      end
      default:   nxt_num = NONE_CODE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_num     <= NONE_CODE;
      irq_valid   <= 1'b0;
      cascade_err <= 1'b0;
    end else begin
      irq_num     <= nxt_num;
      irq_valid   <= (nxt_num != NONE_CODE);
      cascade_err <= cascade_err | casc_empty;
    end
  end
endmodule

// File: rtl/nxt_irq_checker.sv
module nxt_irq_checker
  import nxt_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] sum_word,
  input logic [NUM_W-1:0]  irq_num,
  input logic              irq_valid,
  input logic              cascade_err,
  input logic              casc_empty
);
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> irq_num == NONE_CODE); // R3
  AST_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (!irq_num[7] && irq_num[6:5] != 2'd3 &&
                   !(irq_num[6:5] == 2'd0 && irq_num[4:0] > 5'd7))); // R1
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((sum_word & LIVE_MASK) == '0) |=> !irq_valid); // R2
  AST_LOCAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|sum_word[LOCAL_N-1:0]) |=> (irq_valid && irq_num[6:5] == 2'd0)); // R4
  AST_SC1_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_word[LOCAL_N-1:0] == '0 && |sum_word[SC1_LO +: SC1_N]) |=> irq_num[6:5] == 2'd1); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    casc_empty |=> (cascade_err && !irq_valid)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_err |=> cascade_err); // R9
endmodule

bind nxt_irq_encoder nxt_irq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sum_word(sum_word), .irq_num(irq_num),
  .irq_valid(irq_valid), .cascade_err(cascade_err), .casc_empty(casc_empty)
);

// File: tb/tb_nxt_irq_encoder.sv
`timescale 1ns/1ps
module tb_nxt_irq_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sum_word = '0, bank1_word = '0, bank2_word = '0;
  logic [7:0]  irq_num;
  logic        irq_valid, cascade_err;
  int          errors = 0, checks = 0;
  logic        exp_err = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  nxt_irq_encoder dut (.clk(clk), .rst_n(rst_n), .sum_word(sum_word),
    .bank1_word(bank1_word), .bank2_word(bank2_word),
    .irq_num(irq_num), .irq_valid(irq_valid), .cascade_err(cascade_err));

  int sc_src[11] = '{7, 9, 10, 18, 19, 21, 22, 23, 24, 25, 30};

  function automatic int low_bit(input logic [31:0] w);
    for (int i = 0; i < 32; i++) if (w[i]) return i;
    return -1;
  endfunction

  // Reference: returns the expected number (255 = none); sets casc_bad.
  function automatic int ref_num(input logic [31:0] s, input logic [31:0] b1,
                                 input logic [31:0] b2, output bit casc_bad);
    int k;
    casc_bad = 0;
    for (int i = 0; i < 8; i++) if (s[i]) return i;
    for (int i = 10; i <= 20; i++)
      if (s[i]) return ((i < 15) ? 1 : 2) * 32 + sc_src[i-10];
    if (s[8]) begin
      k = low_bit(b1);
      if (k < 0) begin casc_bad = 1; return 255; end
      return 32 + k;
    end
    if (s[9]) begin
      k = low_bit(b2);
      if (k < 0) begin casc_bad = 1; return 255; end
      return 64 + k;
    end
    return 255;
  endfunction

  task automatic check(input string tag, input int exp_n, input bit exp_v, input bit exp_e);
    checks++;
    if (irq_num !== 8'(exp_n) || irq_valid !== exp_v || cascade_err !== exp_e) begin
      errors++;
      $display("FAIL %s: num=%0d valid=%0b err=%0b expected num=%0d valid=%0b err=%0b",
               tag, irq_num, irq_valid, cascade_err, exp_n, exp_v, exp_e);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] s,
                       input logic [31:0] b1, input logic [31:0] b2);
    int n;
    bit bad;
    @(negedge clk);
    sum_word = s; bank1_word = b1; bank2_word = b2;
    n = ref_num(s, b1, b2, bad);
    exp_err = exp_err | bad;
    @(posedge clk);
    @(negedge clk);
    check(tag, n, n != 255, exp_err);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10 in reset", 255, 0, 0);
    rst_n = 1'b1;
    exp_err = 1'b0;
    check("R10 after reset", 255, 0, 0);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R3: nothing pending
    apply("R3 idle", 32'h0, 32'h0, 32'h0);
    // R2: ignored upper bits, each alone and together
    for (int i = 21; i < 32; i++) apply("R2 upper bit", 32'h1 << i, 32'h4, 32'h8);
    apply("R2 all upper", 32'hFFE0_0000, 32'h1, 32'h1);
    // R1 R5 R6 R7: each live bit alone
    for (int i = 0; i < 21; i++) apply("R1 R6 single bit", 32'h1 << i, 32'h8000_0100, 32'h0004_0000);
    // R7: cascade into every bank bit
    for (int i = 0; i < 32; i++) begin
      apply("R7 bank1", 32'h100, 32'h1 << i, 32'h1);
      apply("R7 bank2", 32'h200, 32'h1, 32'h1 << i);
    end
    apply("R5 bank1 lowest", 32'h100, 32'hF000_0F00, 32'h0);
    // R4 R5: every pair of live bits
    for (int i = 0; i < 21; i++)
      for (int j = i + 1; j < 21; j++)
        apply("R4 R5 pair", (32'h1 << i) | (32'h1 << j), 32'h0002_0000, 32'h0000_4000);
    // R4: random patterns with sparse summary words
    for (int t = 0; t < 3000; t++)
      apply("R4 random", $urandom & $urandom & $urandom, $urandom | 32'h8000_0000,
            $urandom | 32'h8000_0000);
    // R8: cascade to an empty bank
    apply("R8 empty bank1", 32'h100, 32'h0, 32'h5);
    // R9: flag stays set
    apply("R9 sticky", 32'h1, 32'h0, 32'h0);
    apply("R9 sticky idle", 32'h0, 32'h0, 32'h0);
    do_reset();
    apply("R8 empty bank2", 32'h200, 32'h5, 32'h0);
    apply("R8 shortcut beats empty cascade", 32'h0000_8300, 32'h0, 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule